// File: doc/BRIEF.md
# Four-Way Pairwise LRU Replacement Tracker

This block holds the replacement state of a 4-way set-associative cache. The cache has 256 sets by default, selected by address bits 11 to 4, and 16-byte lines. Every set keeps six order bits. Each bit records, for one pair of ways, which way of the pair was used longer ago. Together the six bits form a total recency order of the four ways, and only 24 of the 64 six-bit values are legal.

The cache controller reports every hit or fill on a single access port. It gives a valid strobe, the set index and the way. The port has no ready signal: it accepts an access in every cycle, so it never applies back-pressure. On a miss the controller reads the victim way, which is decoded combinationally from the stored bits of the set on the access index. Software can read any set's bits at once and can write them. A write with a pattern that is not a legal order is refused and flagged.

Power-on reset clears every set. Manual reset keeps the stored bits and only freezes the block while it is held.

Top module: `lru4_tracker`

## Requirements
- R1: The block stores six bits per set for `SETS` sets. `sw_rdata` shows, in the same cycle and without a clock edge, the stored bits of the set on `sw_set`.
- R2: While `por_n` is low, every set is cleared to 000000. The error flag is cleared too. A cleared set names way 3 as its victim.
- R3: An accepted access to way w makes w the most recent way of that set. The bits of the three pairs that do not include w are kept. The new value can be read from the next cycle. The effects per way are: way 0 clears bits 5, 4 and 3; way 1 sets bit 5 and clears bits 2 and 1; way 2 sets bits 4 and 2 and clears bit 0; way 3 sets bits 3, 1 and 0.
- R4: `vic_way` is the way that is older than all three other ways in the set on `acc_set`, decoded combinationally. For example, 000000 gives way 3, 111111 gives way 0, 000110 gives way 1 and 000001 gives way 2.
- R5: Each bit covers one pair of ways: bit 5 covers ways 0 and 1, bit 4 covers ways 0 and 2, bit 3 covers ways 0 and 3, bit 2 covers ways 1 and 2, bit 1 covers ways 1 and 3, and bit 0 covers ways 2 and 3. A bit value of 1 means the lower-numbered way of the pair is the older one.
- R6: A software write is legal only when its bits describe a total order of the four ways. There are 24 such patterns. An illegal write leaves the stored bits unchanged, and `wr_err` is high for the one cycle after it.
- R7: While `mrst_n` is low, the stored bits keep their values. Accesses and software writes are ignored, and `wr_err` is low.
- R8: When a legal software write and an access hit the same set in the same cycle, the written value is stored. When the write is illegal, the access update is applied instead.
- R9: A software write and an access to different sets in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| mrst_n | input | 1 | Manual reset, active low; keeps state and freezes updates |
| acc_valid | input | 1 | Hit or fill reported this cycle |
| acc_set | input | IDX_W | Set index of the access and of the victim lookup |
| acc_way | input | 2 | Way that was accessed |
| vic_way | output | 2 | Way to replace in the set on `acc_set` |
| sw_we | input | 1 | Software write strobe |
| sw_set | input | IDX_W | Set index for software read and write |
| sw_wdata | input | 6 | Order bits to write |
| sw_rdata | output | 6 | Stored order bits of the set on `sw_set` |
| wr_err | output | 1 | Previous cycle's write was refused as illegal |

## Verification
The bench builds the tracker with `SETS` = 16. With only 16 sets, random indices send an access and a software write to the same set often enough to exercise both outcomes of the collision rule in R8. The small size also lets the bench sweep every set after each reset and check it. All 24 legal orders, and many illegal values, are written to single sets. This covers the full victim decode and the rejection path in a short run.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  localparam int NWAYS = 4;
  localparam int LRU_W = 6;
  typedef logic [LRU_W-1:0] lru_bits_t;
  typedef logic [1:0]       way_t;

  // Bit position for the pair (a,b) with a < b: (0,1)->5 ... (2,3)->0
  function automatic int pair_bit(input int a, input int b);
    return LRU_W - 1 - (a * 3 - (a * (a - 1)) / 2 + (b - a - 1));
  endfunction
endpackage

// File: rtl/lru4_update.sv
module lru4_update
  import lru4_pkg::*;
(
  input  lru_bits_t cur,
  input  way_t      way,
  output lru_bits_t nxt
);
  always_comb begin
    nxt = cur;
    for (int a = 0; a < NWAYS; a++) begin
      for (int b = a + 1; b < NWAYS; b++) begin
        if (way_t'(a) == way) nxt[pair_bit(a, b)] = 1'b0;
        if (way_t'(b) == way) nxt[pair_bit(a, b)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lru4_decode.sv
module lru4_decode
  import lru4_pkg::*;
(
  input  lru_bits_t bits,
  output way_t      victim,
  output logic      legal
);
  logic [1:0] rank [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_rank
    always_comb begin
      rank[w] = '0;
      for (int x = 0; x < NWAYS; x++) begin
        if (x < w)      rank[w] = rank[w] + {1'b0, ~bits[pair_bit(x, w)]};
        else if (x > w) rank[w] = rank[w] + {1'b0, bits[pair_bit(w, x)]};
      end
    end
  end

  always_comb begin
    logic [NWAYS-1:0] seen;
    seen   = '0;
    victim = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      seen[rank[w]] = 1'b1;
      if (rank[w] == 2'd3) victim = way_t'(w);
    end
    legal = &seen;
  end
endmodule

// File: rtl/lru4_store.sv
module lru4_store
  import lru4_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             hw_we,
  input  logic [IDX_W-1:0] hw_idx,
  input  lru_bits_t        hw_data,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  lru_bits_t        sw_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output lru_bits_t        rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output lru_bits_t        rd_b
);
  lru_bits_t mem [SETS];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else begin
      if (hw_we) mem[hw_idx] <= hw_data;
      if (sw_we) mem[sw_idx] <= sw_data;   // later assignment wins on a shared set
    end
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];
endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
  import lru4_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_set,
  input  logic [1:0]       acc_way,
  output logic [1:0]       vic_way,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_set,
  input  logic [5:0]       sw_wdata,
  output logic [5:0]       sw_rdata,
  output logic             wr_err
);
  lru_bits_t acc_cur, acc_nxt;
  logic      wdata_legal, hw_go, sw_go;
  way_t      unused_way;

  assign sw_go = sw_we & mrst_n & wdata_legal;
  assign hw_go = acc_valid & mrst_n;

  lru4_store #(.SETS(SETS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .por_n(por_n),
    .hw_we(hw_go), .hw_idx(acc_set), .hw_data(acc_nxt),
    .sw_we(sw_go), .sw_idx(sw_set),  .sw_data(sw_wdata),
    .rd_a_idx(acc_set), .rd_a(acc_cur),
    .rd_b_idx(sw_set),  .rd_b(sw_rdata)
  );

  lru4_update u_upd (.cur(acc_cur), .way(acc_way), .nxt(acc_nxt));

  lru4_decode u_vic (.bits(acc_cur), .victim(vic_way), .legal());

  lru4_decode u_chk_wr (.bits(sw_wdata), .victim(unused_way), .legal(wdata_legal));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       wr_err <= 1'b0;
    else if (!mrst_n) wr_err <= 1'b0;
    else              wr_err <= sw_we & ~wdata_legal;
  end
endmodule

// File: rtl/lru4_tracker_chk.sv
module lru4_tracker_chk #(
  parameter int SETS  = 256,
  parameter int IDX_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             por_n,
  input logic             mrst_n,
  input logic             acc_valid,
  input logic [IDX_W-1:0] acc_set,
  input logic [1:0]       acc_way,
  input logic [1:0]       vic_way,
  input logic             sw_we,
  input logic [IDX_W-1:0] sw_set,
  input logic [5:0]       sw_wdata,
  input logic [5:0]       sw_rdata,
  input logic             wr_err
);
  // The way just touched can never be the next victim of that set
  p_touched_not_victim_r3: assert property (@(posedge clk) disable iff (!por_n)
    (acc_valid && mrst_n && !(sw_we && sw_set == acc_set))
    |=> (acc_set != $past(acc_set)) || (vic_way != $past(acc_way)));

  // The error flag only follows a software write outside manual reset
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
    wr_err |-> ($past(sw_we) && $past(mrst_n)));

  p_mrst_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n |=> (sw_set != $past(sw_set)) || $stable(sw_rdata));

  p_mrst_noerr_r7: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n |=> !wr_err);

  // An accepted write is what the set holds afterwards, whatever access collided
  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!por_n)
    (sw_we && mrst_n) |=> wr_err || (sw_set != $past(sw_set))
                          || (sw_rdata == $past(sw_wdata)));
endmodule

bind lru4_tracker lru4_tracker_chk #(.SETS(SETS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .acc_valid(acc_valid),
  .acc_set(acc_set), .acc_way(acc_way), .vic_way(vic_way), .sw_we(sw_we),
  .sw_set(sw_set), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .wr_err(wr_err)
);

// File: tb/sim_lru4_tracker.sv
`timescale 1ns/1ps
module sim_lru4_tracker;
  localparam int SETS  = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             por_n = 1'b0, mrst_n = 1'b1;
  logic             acc_valid = 1'b0, sw_we = 1'b0;
  logic [IDX_W-1:0] acc_set = '0, sw_set = '0;
  logic [1:0]       acc_way = '0, vic_way;
  logic [5:0]       sw_wdata = '0, sw_rdata;
  logic             wr_err;

  lru4_tracker #(.SETS(SETS), .IDX_W(IDX_W)) u0 (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_way(acc_way), .vic_way(vic_way), .sw_we(sw_we),
    .sw_set(sw_set), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .wr_err(wr_err)
  );

  int checks = 0, errors = 0;
  int ord   [SETS][4];   // recency list per set, index 0 = most recent
  int perms [24][4];
  bit exp_err = 0;

  function automatic logic [5:0] enc(input int o [4]);
    // R5 encoding: pair bit is 1 when the lower way sits later in the list
    logic [5:0] r; int pos [4]; int k;
    for (int i = 0; i < 4; i++) pos[o[i]] = i;
    r = '0; k = 5;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++) begin
        r[k] = (pos[a] > pos[b]); k--;
      end
    return r;
  endfunction

  function automatic int find_perm(input logic [5:0] p);
    for (int i = 0; i < 24; i++) if (enc(perms[i]) == p) return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < 4; i++) ord[s][i] = i;
    exp_err = 0;
  endtask

  task automatic touch(input int s, input int w);
    int j;
    j = 0;
    for (int i = 0; i < 4; i++) if (ord[s][i] == w) j = i;
    for (int i = j; i > 0; i--) ord[s][i] = ord[s][i-1];
    ord[s][0] = w;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit av, input int as, input int aw,
                      input bit we, input int ws, input logic [5:0] wd, input bit mr);
    int pi;
    @(negedge clk);
    acc_valid = av; acc_set = as[IDX_W-1:0]; acc_way = aw[1:0];
    sw_we = we; sw_set = ws[IDX_W-1:0]; sw_wdata = wd; mrst_n = mr;
    #1;
    chk("R1/R3 sw_rdata", sw_rdata, enc(ord[ws]));
    chk("R4 vic_way", vic_way, ord[as][3]);
    chk("R6 wr_err", wr_err, exp_err);
    @(posedge clk);
    pi = find_perm(wd);
    if (mr) begin
      if (we && pi >= 0)
        for (int i = 0; i < 4; i++) ord[ws][i] = perms[pi][i];
      if (av && !(we && pi >= 0 && ws == as)) touch(as, aw);   // R8, R9
      exp_err = we && (pi < 0);
    end else exp_err = 0;                                      // R7
  endtask

  task automatic sweep();
    for (int s = 0; s < SETS; s++) step(0, s, 0, 0, s, 6'd0, 1);
  endtask

  initial begin
    int n;
    n = 0;
    for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++)
      for (int c = 0; c < 4; c++) for (int d = 0; d < 4; d++)
        if (a != b && a != c && a != d && b != c && b != d && c != d) begin
          perms[n][0] = a; perms[n][1] = b; perms[n][2] = c; perms[n][3] = d; n++;
        end
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1'b1;
    // R2: all sets clear, victim way 3
    sweep();
    // R4, R5: every legal order written to one set, read and decoded
    for (int i = 0; i < 24; i++) begin
      step(0, 5, 0, 1, 5, enc(perms[i]), 1);
      step(0, 5, 0, 0, 5, 6'd0, 1);
    end
    // R3: touch each way in turn
    for (int w = 0; w < 4; w++) step(1, 5, w, 0, 5, 6'd0, 1);
    step(0, 5, 0, 0, 5, 6'd0, 1);
    // R6: illegal pattern refused
    step(0, 5, 0, 1, 5, 6'b101010, 1);
    step(0, 5, 0, 0, 5, 6'd0, 1);
    step(0, 5, 0, 0, 5, 6'd0, 1);
    // R8: same-set collision, legal then illegal write
    step(1, 7, 1, 1, 7, 6'b111111, 1);
    step(0, 7, 0, 0, 7, 6'd0, 1);
    step(1, 7, 2, 1, 7, 6'b010101, 1);
    step(0, 7, 0, 0, 7, 6'd0, 1);
    // R9: different sets same cycle
    step(1, 3, 0, 1, 4, 6'b000110, 1);
    step(0, 3, 0, 0, 4, 6'd0, 1);
    // R7: manual reset holds state and blocks changes
    step(1, 3, 3, 1, 3, 6'b111111, 0);
    step(0, 3, 0, 1, 3, 6'b101010, 0);
    step(0, 3, 0, 0, 3, 6'd0, 1);
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] wd;
      wd = ($urandom_range(0, 9) < 8) ? enc(perms[$urandom_range(0, 23)])
                                      : 6'($urandom_range(0, 63));
      step($urandom_range(0, 9) < 7, $urandom_range(0, SETS-1), $urandom_range(0, 3),
           $urandom_range(0, 4) == 0, $urandom_range(0, SETS-1), wd,
           $urandom_range(0, 19) != 0);
    end
    // R2: power-on reset again clears everything
    @(negedge clk); por_n = 1'b0; sw_we = 1'b0; acc_valid = 1'b0;
    model_clear();
    @(negedge clk); por_n = 1'b1;
    sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule